// File: doc/BRIEF.md
# Four-Device Byte SRAM Bus Controller

This block sits between a shared system bus and a bank of four byte-wide static RAM devices. A requester on the bus presents an 8-bit address, a data byte and a read/write select, and pulses an address strobe. The controller captures the request, works out which device the address falls in, and runs a short control sequence on that device's chip enable together with the shared write-enable and output-enable lines.

The 256-byte bus address space is divided evenly, 64 bytes per device. The two upper address bits choose the device and the six lower bits become the device-local address. A write completes in one enabled cycle. A read enables the device for one cycle, samples its data at the end of that cycle, and presents the byte on the bus in the cycle after, flagged by a return-valid output. A ready output tells the requester when a new strobe will be taken. Strobes that arrive at any other time are dropped.

Top module: `memctl_top`

## Requirements
- R1: Bus address bit [7:6] selects the device (value d drives chip enable bit d), and bits [5:0] appear on the device address output while that device is enabled.
- R2: When the controller is idle (bus_ready high), a strobe at a clock edge starts an access: bus_rd_wr_n = 1 starts a read and 0 starts a write, and bus_ready falls in the following cycle.
- R3: A write holds the selected chip enable and mem_we high for exactly one cycle, directly after acceptance, with mem_oe low and the captured address and data on mem_addr and mem_wdata. The addressed byte of the selected device is updated.
- R4: A read holds the selected chip enable and mem_oe high for exactly one cycle, directly after acceptance, with mem_we low. The device's data is sampled at the end of that cycle.
- R5: In the cycle after the read-enable cycle, bus_rvalid is high and bus_rdata carries the sampled byte. In every other cycle bus_rvalid is low and bus_rdata is zero.
- R6: At most one chip enable is high at any time. All chip enables, mem_we and mem_oe are low while idle and while reset is held.
- R7: A strobe that arrives while an access is in progress is ignored and leaves memory unchanged. The controller is ready again 2 cycles after a write is accepted and 3 cycles after a read is accepted.
- R8: The synchronous active-high reset returns the controller to idle at the next edge, including in the middle of an access.
- R9: Address, data and direction are captured at acceptance. Later changes on the bus inputs do not alter an access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_strobe | input | 1 | Address strobe, starts an access when idle |
| bus_rd_wr_n | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 8 | Bus byte address |
| bus_wdata | input | 8 | Write data from the bus |
| bus_rdata | output | 8 | Read data returned to the bus, zero outside the return cycle |
| bus_rvalid | output | 1 | High in the read-return cycle |
| bus_ready | output | 1 | High when idle and able to accept a strobe |
| mem_ce | output | 4 | Per-device chip enables, active high |
| mem_we | output | 1 | Shared write enable, active high |
| mem_oe | output | 1 | Shared output enable, active high |
| mem_addr | output | 6 | Device-local address |
| mem_wdata | output | 8 | Write data to the devices |
| mem_rdata | input | 32 | Device read data, device d on bits [8d+7:8d] |

## Verification
A corrupted phase register shows up as an enable that lasts one cycle too long or too short, or as bus_ready returning at the wrong cycle count. Either appears on the ports within one to three cycles of the strobe. A wrong captured request shows up in the enable cycle itself, as the wrong chip-enable bit or the wrong mem_addr or mem_wdata. A corrupted read-capture register shows up one cycle later as a bad bus_rdata. After the full address map is filled and read back, a write that reached the wrong device shows up as a read mismatch on a later access to either address.

// File: rtl/memctl_pkg.sv
package memctl_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int DEV_N  = 4;
    localparam int SEL_W  = $clog2(DEV_N);
    localparam int LOC_W  = ADDR_W - SEL_W;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WRITE  = 2'd1,
        PH_READ   = 2'd2,
        PH_RETURN = 2'd3
    } phase_e;

    typedef struct packed {
        logic [SEL_W-1:0]  dev;
        logic [LOC_W-1:0]  loc;
        logic [DATA_W-1:0] wdata;
    } access_t;

    function automatic access_t pack_access(input logic [ADDR_W-1:0] addr,
                                            input logic [DATA_W-1:0] data);
        access_t a;
        a.dev   = addr[ADDR_W-1 -: SEL_W];
        a.loc   = addr[LOC_W-1:0];
        a.wdata = data;
        return a;
    endfunction

    function automatic logic [DEV_N-1:0] dev_onehot(input logic [SEL_W-1:0] idx);
        logic [DEV_N-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/memctl_seq.sv
module memctl_seq
    import memctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe,
    input  logic   rd_wr_n,
    output phase_e phase,
    output logic   accept,
    output logic   ready
);
    phase_e phase_nxt;

    assign ready  = (phase == PH_IDLE);
    assign accept = ready && strobe;

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE:   if (strobe) phase_nxt = rd_wr_n ? PH_READ : PH_WRITE;
            PH_WRITE:  phase_nxt = PH_IDLE;
            PH_READ:   phase_nxt = PH_RETURN;
            PH_RETURN: phase_nxt = PH_IDLE;
            default:   phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nxt;
    end

    // R2: an accepted strobe always leaves idle at the next edge
    assert_accept_leaves_idle_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);
    // R3: a write phase lasts one cycle
    assert_write_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE) |=> (phase == PH_IDLE));
endmodule

// File: rtl/memctl_latch.sv
module memctl_latch
    import memctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output access_t           cur
);
    always_ff @(posedge clk) begin
        if (rst)         cur <= '0;
        else if (accept) cur <= pack_access(addr, wdata);
    end

    // R9: the captured request only changes on acceptance
    assert_hold_request_R9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(cur));
endmodule

// File: rtl/memctl_drive.sv
module memctl_drive
    import memctl_pkg::*;
(
    input  phase_e            phase,
    input  access_t           cur,
    output logic [DEV_N-1:0]  mem_ce,
    output logic              mem_we,
    output logic              mem_oe,
    output logic [LOC_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic             active;
    logic [DEV_N-1:0] sel;

    assign active = (phase == PH_WRITE) || (phase == PH_READ);
    assign sel    = dev_onehot(cur.dev);

    for (genvar g = 0; g < DEV_N; g++) begin : g_ce
        assign mem_ce[g] = active && sel[g];
    end

    assign mem_we    = (phase == PH_WRITE);
    assign mem_oe    = (phase == PH_READ);
    assign mem_addr  = active ? cur.loc : '0;
    assign mem_wdata = (phase == PH_WRITE) ? cur.wdata : '0;

    // R6: never two devices enabled
    always_comb begin
        assert_ce_onehot_R6: assert ($onehot0(mem_ce));
    end
endmodule

// File: rtl/memctl_rdret.sv
module memctl_rdret
    import memctl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  phase_e                  phase,
    input  logic [SEL_W-1:0]        dev,
    input  logic [DEV_N*DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_rvalid
);
    logic [DATA_W-1:0] lanes [DEV_N];
    logic [DATA_W-1:0] cap;

    for (genvar g = 0; g < DEV_N; g++) begin : g_lane
        assign lanes[g] = mem_rdata[g*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst)                   cap <= '0;
        else if (phase == PH_READ) cap <= lanes[dev];
    end

    assign bus_rvalid = (phase == PH_RETURN);
    assign bus_rdata  = bus_rvalid ? cap : '0;
endmodule

// File: rtl/memctl_top.sv
module memctl_top
    import memctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_strobe,
    input  logic        bus_rd_wr_n,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_rvalid,
    output logic        bus_ready,
    output logic [3:0]  mem_ce,
    output logic        mem_we,
    output logic        mem_oe,
    output logic [5:0]  mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [31:0] mem_rdata
);
    phase_e  phase;
    logic    accept;
    access_t cur;

    memctl_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .strobe  (bus_strobe),
        .rd_wr_n (bus_rd_wr_n),
        .phase   (phase),
        .accept  (accept),
        .ready   (bus_ready)
    );

    memctl_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cur    (cur)
    );

    memctl_drive u_drive (
        .phase     (phase),
        .cur       (cur),
        .mem_ce    (mem_ce),
        .mem_we    (mem_we),
        .mem_oe    (mem_oe),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    memctl_rdret u_rdret (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .dev        (cur.dev),
        .mem_rdata  (mem_rdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    // R6: idle means every device control is off
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        bus_ready |-> (mem_ce == '0 && !mem_we && !mem_oe));
    // R3: write and read enables are exclusive, and a write pulse lasts one cycle
    assert_we_oe_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_oe));
    assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
    // R4/R5: output enable is followed by the return cycle
    assert_oe_then_return_R5: assert property (@(posedge clk) disable iff (rst)
        mem_oe |=> (bus_rvalid && !mem_oe));
    // R7: after the return cycle the controller is ready
    assert_return_then_ready_R7: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |=> bus_ready);
    // R8: reset forces idle with all controls off
    assert_reset_idle_R8: assert property (@(posedge clk)
        rst |=> (bus_ready && mem_ce == '0 && !mem_we && !mem_oe && !bus_rvalid));
endmodule

// File: tb/memctl_top_tb.sv
module memctl_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_strobe = 1'b0;
    logic        bus_rd_wr_n = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic        bus_ready;
    logic [3:0]  mem_ce;
    logic        mem_we;
    logic        mem_oe;
    logic [5:0]  mem_addr;
    logic [7:0]  mem_wdata;
    logic [31:0] mem_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] ram    [256];
    logic [7:0] shadow [256];

    always #5 clk = ~clk;

    memctl_top u_dut (
        .clk(clk), .rst(rst), .bus_strobe(bus_strobe), .bus_rd_wr_n(bus_rd_wr_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_ready(bus_ready), .mem_ce(mem_ce),
        .mem_we(mem_we), .mem_oe(mem_oe), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Four byte-wide SRAM devices modelled as one 256-entry array
    always @(posedge clk) begin
        for (int d = 0; d < 4; d++)
            if (mem_ce[d] && mem_we) ram[{2'(d), mem_addr}] <= mem_wdata;
    end

    always_comb begin
        mem_rdata = '0;
        for (int d = 0; d < 4; d++)
            if (mem_ce[d] && mem_oe) mem_rdata[d*8 +: 8] = ram[{2'(d), mem_addr}];
    end

    function automatic logic [3:0] exp_ce(input logic [7:0] a);
        return 4'b0001 << a[7:6];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic idle_checks(input string tag);
        check({tag, " R7 ready"}, 32'(bus_ready), 1);
        check({tag, " R6 ce"}, 32'(mem_ce), 0);
        check({tag, " R6 we/oe"}, 32'({mem_we, mem_oe}), 0);
        check({tag, " R5 idle rdata/rvalid"}, 32'({bus_rvalid, bus_rdata}), 0);
    endtask

    // Called at a negedge with the controller idle
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_strobe = 1'b1; bus_rd_wr_n = 1'b0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_strobe = 1'b0;
        check("R2 busy after write accept", 32'(bus_ready), 0);
        check("R1 write ce", 32'(mem_ce), 32'(exp_ce(a)));
        check("R1 write local addr", 32'(mem_addr), 32'(a[5:0]));
        check("R3 we/oe", 32'({mem_we, mem_oe}), 32'(2'b10));
        check("R3 wdata", 32'(mem_wdata), 32'(d));
        shadow[a] = d;
        @(negedge clk);
        check("R7 ready 2 cycles after write", 32'(bus_ready), 1);
        check("R3 device byte written", 32'(ram[a]), 32'(d));
    endtask

    task automatic bus_read(input logic [7:0] a);
        bus_strobe = 1'b1; bus_rd_wr_n = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_strobe = 1'b0;
        check("R2 busy after read accept", 32'(bus_ready), 0);
        check("R1 read ce", 32'(mem_ce), 32'(exp_ce(a)));
        check("R1 read local addr", 32'(mem_addr), 32'(a[5:0]));
        check("R4 oe/we", 32'({mem_oe, mem_we}), 32'(2'b10));
        @(negedge clk);
        check("R5 rvalid", 32'(bus_rvalid), 1);
        check("R5 rdata", 32'(bus_rdata), 32'(shadow[a]));
        check("R4 enables off in return", 32'({mem_ce, mem_oe}), 0);
        @(negedge clk);
        check("R7 ready 3 cycles after read", 32'(bus_ready), 1);
        check("R5 rdata zero after return", 32'({bus_rvalid, bus_rdata}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] seed_v;
        for (int i = 0; i < 256; i++) shadow[i] = '0;
        seed_v = $urandom(32'h00C0FFEE);

        // Reset state, with a strobe held during reset (R8, R6)
        bus_strobe = 1'b1;
        repeat (3) @(negedge clk);
        idle_checks("reset");
        bus_strobe = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        idle_checks("post-reset");

        // Exhaustive address map: fill then read back (R1, R3, R4, R5)
        for (int a = 0; a < 256; a++) bus_write(8'(a), 8'(a) ^ 8'hA5);
        for (int a = 0; a < 256; a++) bus_read(8'(a));

        // Device boundaries
        bus_write(8'h3F, 8'h11); bus_write(8'h40, 8'h22);
        bus_write(8'hBF, 8'h33); bus_write(8'hC0, 8'h44);
        bus_read(8'h3F); bus_read(8'h40); bus_read(8'hBF); bus_read(8'hC0);

        // Strobe and bus changes during a write are ignored (R7, R9)
        bus_strobe = 1'b1; bus_rd_wr_n = 1'b0; bus_addr = 8'h05; bus_wdata = 8'h3C;
        @(negedge clk);
        bus_addr = 8'hC5; bus_wdata = 8'h99; bus_rd_wr_n = 1'b0;
        #1;
        check("R9 addr held", 32'(mem_addr), 32'h05);
        check("R9 data held", 32'(mem_wdata), 32'h3C);
        check("R9 ce held", 32'(mem_ce), 32'b0001);
        shadow[8'h05] = 8'h3C;
        @(negedge clk);
        bus_strobe = 1'b0;
        idle_checks("after ignored write strobe");
        check("R7 ignored write left memory", 32'(ram[8'hC5]), 32'(shadow[8'hC5]));
        check("R3 held write landed", 32'(ram[8'h05]), 32'h3C);

        // Strobe during read enable and return cycles is ignored (R7)
        bus_strobe = 1'b1; bus_rd_wr_n = 1'b1; bus_addr = 8'h40;
        @(negedge clk);
        bus_rd_wr_n = 1'b0; bus_addr = 8'h41; bus_wdata = 8'hEE;
        @(negedge clk);
        check("R5 rdata with strobe held", 32'(bus_rdata), 32'(shadow[8'h40]));
        check("R7 busy in return", 32'(bus_ready), 0);
        @(negedge clk);
        bus_strobe = 1'b0;
        idle_checks("after ignored read strobe");
        check("R7 ignored strobe left memory", 32'(ram[8'h41]), 32'(shadow[8'h41]));

        // Reset in the middle of a read (R8)
        bus_strobe = 1'b1; bus_rd_wr_n = 1'b1; bus_addr = 8'h80;
        @(negedge clk);
        bus_strobe = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        idle_checks("R8 mid-read reset");
        rst = 1'b0;
        @(negedge clk);
        // Reset in the middle of a write (R8)
        bus_strobe = 1'b1; bus_rd_wr_n = 1'b0; bus_addr = 8'h81; bus_wdata = 8'h5A;
        @(negedge clk);
        bus_strobe = 1'b0;
        rst = 1'b1;
        shadow[8'h81] = 8'h5A;
        @(negedge clk);
        idle_checks("R8 mid-write reset");
        rst = 1'b0;
        @(negedge clk);
        bus_read(8'h81);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            a = 8'($urandom);
            if ($urandom_range(1, 0) == 1) bus_write(a, 8'($urandom));
            else                           bus_read(a);
        end

        finish_run();
    end
endmodule